// File: doc/BRIEF.md
# Flash command register controller

This block is the command-decoding state machine of a byte-wide, 128K x 8 flash memory that is erased as a whole chip and programmed one byte at a time. Bus write cycles arrive as single-cycle strobes carrying an address and a data byte. Read strobes carry an address. From the sequence of command bytes the block selects one mode at a time: array read, identifier read, erase, program, erase verify, program verify, or halted after the stop timer expires. It issues one-cycle start pulses to the cell array and picks what the registered data output shows. The cells are outside the block. They are reached through an array address output and an array data input.

Command access depends on two digital supply inputs. While the program supply is low, the block is a read-only memory and its command state is held at array read. While the core supply is below the lockout level, every command write is dropped. Erase and program both need two writes: a setup byte, then a confirming write. Once started, the operation stays busy until the next accepted write ends it, normally a verify or a reset. If no such write comes, a stop timer of STOP_CYCLES clock cycles ends the operation and the block waits in a halted state.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: While `vpp_hi` is 0, the mode is array read from the next clock edge on (`rd_array`=1, `busy`=0), and writes have no effect on the mode.
- R2: While `lockout` is 1, a write strobe changes no mode output (`rd_array`, `ident`, `verify`).
- R3: After reset, and after a write of byte 00h, the mode is array read. A read strobe at address A returns the array byte at A on `dout` one cycle after the strobe.
- R4: A write of 90h selects identifier mode (`ident`=1). Reads with address bit 0 = 0 return 20h and reads with bit 0 = 1 return 07h. The mode lasts until another command is written.
- R5: The write pair 20h, 20h raises `erase_go` for exactly one cycle, and `busy` rises with it. If 20h is followed by any other byte, `erase_go` stays low and the mode returns to array read.
- R6: After setup byte 40h, the next write raises `prog_go` for one cycle with `prog_addr`/`prog_data` equal to that write's address and data. `busy` rises with it.
- R7: A write of A0h latches that write's address. In this mode (`verify`=1), reads return the array byte at the latched address, whatever the read address.
- R8: A write of C0h selects program verify (`verify`=1). Reads return the array byte at the last programmed address.
- R9: Two consecutive writes of FFh return the mode to array read. If FFh is followed by another byte, that byte is decoded as a new command.
- R10: With no write, `busy` stays high for exactly STOP_CYCLES cycles. It then drops, and `timeout` pulses for one cycle. In the halted state all mode outputs are 0 and reads return 00h until a command is written.
- R11: A command byte outside {00h, 20h, 40h, 90h, A0h, C0h, FFh}, written as a first byte, returns the mode to array read.
- R12: Any accepted write while `busy` is high ends the operation: `busy` is 0 one cycle after that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vpp_hi | input | 1 | Program supply at write level (1) or read-only level (0) |
| lockout | input | 1 | Core supply below the write lockout level |
| wr_en | input | 1 | One-cycle bus write strobe |
| wr_addr | input | ADDR_W | Address latched with the write |
| wr_data | input | 8 | Command or data byte of the write |
| rd_en | input | 1 | One-cycle read strobe |
| rd_addr | input | ADDR_W | Read address |
| arr_q | input | 8 | Byte returned by the cell array at `arr_addr` |
| arr_addr | output | ADDR_W | Address presented to the cell array |
| dout | output | 8 | Registered read data |
| rd_array | output | 1 | Array read mode |
| ident | output | 1 | Identifier mode |
| verify | output | 1 | Erase or program verify mode |
| busy | output | 1 | Erase or program in progress |
| erase_go | output | 1 | One-cycle chip erase start |
| prog_go | output | 1 | One-cycle byte program start |
| prog_addr | output | ADDR_W | Address of the byte to program |
| prog_data | output | 8 | Byte to program |
| timeout | output | 1 | One-cycle stop timer expiry |

## Verification
The mode outputs, `busy` and the start pulses are all registered at the clock edge that takes the write. They are due one cycle after the write strobe, so the bench samples them at the falling edge that ends the strobe. `dout` is loaded at the edge that takes a read strobe and is checked at the falling edge after it. The stop timer is checked by counting, one falling edge at a time, the cycles in which `busy` is high after the confirming write. That count must equal STOP_CYCLES, and the first low cycle must carry `timeout`. The supply and lockout cases compare the mode outputs one edge after the input or ignored write.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  localparam int BYTE_W = 8;

  localparam logic [BYTE_W-1:0] OP_READ  = 8'h00;
  localparam logic [BYTE_W-1:0] OP_IDENT = 8'h90;
  localparam logic [BYTE_W-1:0] OP_ERASE = 8'h20;
  localparam logic [BYTE_W-1:0] OP_PROG  = 8'h40;
  localparam logic [BYTE_W-1:0] OP_EVFY  = 8'hA0;
  localparam logic [BYTE_W-1:0] OP_PVFY  = 8'hC0;
  localparam logic [BYTE_W-1:0] OP_RESET = 8'hFF;

  typedef enum logic [3:0] {
    ST_READ,
    ST_IDENT,
    ST_ERS_SET,
    ST_ERS_RUN,
    ST_PGM_SET,
    ST_PGM_RUN,
    ST_EVFY,
    ST_PVFY,
    ST_RST_SET,
    ST_HALT
  } st_e;

  typedef enum logic [2:0] {
    CMD_READ,
    CMD_IDENT,
    CMD_ERASE,
    CMD_PROG,
    CMD_EVFY,
    CMD_PVFY,
    CMD_RESET,
    CMD_BAD
  } cmd_e;

  // Mode entered when a byte is taken as the first write of a command
  function automatic st_e first_state(cmd_e c);
    st_e s;
    case (c)
      CMD_READ:  s = ST_READ;
      CMD_IDENT: s = ST_IDENT;
      CMD_ERASE: s = ST_ERS_SET;
      CMD_PROG:  s = ST_PGM_SET;
      CMD_EVFY:  s = ST_EVFY;
      CMD_PVFY:  s = ST_PVFY;
      CMD_RESET: s = ST_RST_SET;
      default:   s = ST_READ;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/flash_rst_sync.sv
module flash_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_out = sync_q[STAGES-1];

endmodule

// File: rtl/flash_cmd_decode.sv
module flash_cmd_decode
  import flash_cmd_pkg::*;
(
  input  logic [BYTE_W-1:0] byte_in,
  output cmd_e              cmd
);

  always_comb begin
    case (byte_in)
      OP_READ:  cmd = CMD_READ;
      OP_IDENT: cmd = CMD_IDENT;
      OP_ERASE: cmd = CMD_ERASE;
      OP_PROG:  cmd = CMD_PROG;
      OP_EVFY:  cmd = CMD_EVFY;
      OP_PVFY:  cmd = CMD_PVFY;
      OP_RESET: cmd = CMD_RESET;
      default:  cmd = CMD_BAD;
    endcase
  end

endmodule

// File: rtl/flash_stop_timer.sv
module flash_stop_timer #(
  parameter int LIMIT = 100000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic hit
);

  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign hit = run && (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (!run) begin
      cnt_d = '0;
    end else if (!hit) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vpp_hi,
  input  logic              lockout,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  cmd_e              cmd,
  input  logic              tmo_hit,
  output st_e               state,
  output logic              erase_go,
  output logic              prog_go,
  output logic              timeout,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [BYTE_W-1:0] prog_data,
  output logic [ADDR_W-1:0] vfy_addr
);

  st_e  state_q, state_d;
  logic ers_d, pgm_d, tmo_d;
  logic pgm_lat, vfy_lat;
  logic acc;

  assign acc = wr_en && vpp_hi && !lockout;

  always_comb begin
    state_d = state_q;
    ers_d   = 1'b0;
    pgm_d   = 1'b0;
    tmo_d   = 1'b0;
    pgm_lat = 1'b0;
    vfy_lat = 1'b0;
    if (!vpp_hi) begin
      state_d = ST_READ;
    end else if (acc) begin
      case (state_q)
        ST_ERS_SET: begin
          if (cmd == CMD_ERASE) begin
            state_d = ST_ERS_RUN;
            ers_d   = 1'b1;
          end else begin
            state_d = ST_READ;
          end
        end
        ST_PGM_SET: begin
          state_d = ST_PGM_RUN;
          pgm_d   = 1'b1;
          pgm_lat = 1'b1;
        end
        ST_RST_SET: begin
          if (cmd == CMD_RESET) begin
            state_d = ST_READ;
          end else begin
            state_d = first_state(cmd);
            vfy_lat = (cmd == CMD_EVFY);
          end
        end
        default: begin
          state_d = first_state(cmd);
          vfy_lat = (cmd == CMD_EVFY);
        end
      endcase
    end else if (tmo_hit) begin
      state_d = ST_HALT;
      tmo_d   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_READ;
      erase_go <= 1'b0;
      prog_go  <= 1'b0;
      timeout  <= 1'b0;
    end else begin
      state_q  <= state_d;
      erase_go <= ers_d;
      prog_go  <= pgm_d;
      timeout  <= tmo_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_addr <= '0;
      prog_data <= '0;
    end else if (pgm_lat) begin
      prog_addr <= wr_addr;
      prog_data <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vfy_addr <= '0;
    end else if (vfy_lat) begin
      vfy_addr <= wr_addr;
    end
  end

  assign state = state_q;

endmodule

// File: rtl/flash_out_mux.sv
module flash_out_mux
  import flash_cmd_pkg::*;
#(
  parameter int              ADDR_W   = 17,
  parameter logic [BYTE_W-1:0] MFR_CODE = 8'h20,
  parameter logic [BYTE_W-1:0] DEV_CODE = 8'h07
) (
  input  logic              clk,
  input  logic              rst_n,
  input  st_e               state,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [ADDR_W-1:0] vfy_addr,
  input  logic [ADDR_W-1:0] prog_addr,
  input  logic [BYTE_W-1:0] arr_q,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [BYTE_W-1:0] dout
);

  logic [BYTE_W-1:0] dout_d;

  always_comb begin
    case (state)
      ST_EVFY: arr_addr = vfy_addr;
      ST_PVFY: arr_addr = prog_addr;
      default: arr_addr = rd_addr;
    endcase
  end

  always_comb begin
    case (state)
      ST_READ, ST_EVFY, ST_PVFY: dout_d = arr_q;
      ST_IDENT:                  dout_d = rd_addr[0] ? DEV_CODE : MFR_CODE;
      default:                   dout_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout <= '0;
    end else if (rd_en) begin
      dout <= dout_d;
    end
  end

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int              ADDR_W      = 17,
  parameter int              STOP_CYCLES = 100000,
  parameter int              RST_STAGES  = 2,
  parameter logic [BYTE_W-1:0] MFR_CODE    = 8'h20,
  parameter logic [BYTE_W-1:0] DEV_CODE    = 8'h07
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vpp_hi,
  input  logic              lockout,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [BYTE_W-1:0] arr_q,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [BYTE_W-1:0] dout,
  output logic              rd_array,
  output logic              ident,
  output logic              verify,
  output logic              busy,
  output logic              erase_go,
  output logic              prog_go,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [BYTE_W-1:0] prog_data,
  output logic              timeout
);

  logic              rst_n_s;
  cmd_e              cmd;
  st_e               state;
  logic              tmo_hit;
  logic [ADDR_W-1:0] vfy_addr;

  flash_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  flash_cmd_decode u_dec (
    .byte_in (wr_data),
    .cmd     (cmd)
  );

  flash_cmd_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .vpp_hi    (vpp_hi),
    .lockout   (lockout),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .cmd       (cmd),
    .tmo_hit   (tmo_hit),
    .state     (state),
    .erase_go  (erase_go),
    .prog_go   (prog_go),
    .timeout   (timeout),
    .prog_addr (prog_addr),
    .prog_data (prog_data),
    .vfy_addr  (vfy_addr)
  );

  assign busy     = (state == ST_ERS_RUN) || (state == ST_PGM_RUN);
  assign rd_array = (state == ST_READ);
  assign ident    = (state == ST_IDENT);
  assign verify   = (state == ST_EVFY) || (state == ST_PVFY);

  flash_stop_timer #(.LIMIT(STOP_CYCLES)) u_tmr (
    .clk   (clk),
    .rst_n (rst_n_s),
    .run   (busy),
    .hit   (tmo_hit)
  );

  flash_out_mux #(
    .ADDR_W   (ADDR_W),
    .MFR_CODE (MFR_CODE),
    .DEV_CODE (DEV_CODE)
  ) u_out (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .state     (state),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .vfy_addr  (vfy_addr),
    .prog_addr (prog_addr),
    .arr_q     (arr_q),
    .arr_addr  (arr_addr),
    .dout      (dout)
  );

endmodule

// File: rtl/flash_cmd_chk.sv
module flash_cmd_chk #(
  parameter int STOP_CYCLES = 100000
) (
  input logic clk,
  input logic rst_n,
  input logic vpp_hi,
  input logic lockout,
  input logic wr_en,
  input logic rd_array,
  input logic ident,
  input logic verify,
  input logic busy,
  input logic erase_go,
  input logic prog_go,
  input logic timeout
);

  logic [31:0] busy_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_cnt <= '0;
    end else if (busy) begin
      busy_cnt <= busy_cnt + 1'b1;
    end else begin
      busy_cnt <= '0;
    end
  end

  AST_SUPPLY_LOW_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !vpp_hi |=> (rd_array && !busy)); // R1

  AST_LOCKOUT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (lockout && wr_en && vpp_hi) |=> $stable({rd_array, ident, verify})); // R2

  AST_ERASE_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    erase_go |=> !erase_go); // R5

  AST_ERASE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    erase_go |-> busy); // R5

  AST_PROG_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    prog_go |-> (busy && !erase_go)); // R6

  AST_TIMEOUT_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> (!busy && $past(busy))); // R10

  AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (busy_cnt < 32'(STOP_CYCLES))); // R10

  AST_ONE_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_array, ident, verify, busy})); // R11

endmodule

bind flash_cmd_ctrl flash_cmd_chk #(.STOP_CYCLES(STOP_CYCLES)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .vpp_hi   (vpp_hi),
  .lockout  (lockout),
  .wr_en    (wr_en),
  .rd_array (rd_array),
  .ident    (ident),
  .verify   (verify),
  .busy     (busy),
  .erase_go (erase_go),
  .prog_go  (prog_go),
  .timeout  (timeout)
);

// File: tb/sim_flash_cmd_ctrl.sv
`timescale 1ns/1ps
module sim_flash_cmd_ctrl;

  localparam int AW   = 17;
  localparam int STOP = 40;
  localparam int MW   = 10;

  logic          clk;
  logic          rst_n;
  logic          vpp_hi;
  logic          lockout;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [7:0]    wr_data;
  logic          rd_en;
  logic [AW-1:0] rd_addr;
  logic [7:0]    arr_q;
  logic [AW-1:0] arr_addr;
  logic [7:0]    dout;
  logic          rd_array, ident, verify, busy;
  logic          erase_go, prog_go, timeout;
  logic [AW-1:0] prog_addr;
  logic [7:0]    prog_data;

  logic [7:0] mem [0:(1<<MW)-1];

  int n_chk = 0;
  int n_err = 0;

  flash_cmd_ctrl #(.ADDR_W(AW), .STOP_CYCLES(STOP)) u0 (
    .clk(clk), .rst_n(rst_n), .vpp_hi(vpp_hi), .lockout(lockout),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .arr_q(arr_q), .arr_addr(arr_addr),
    .dout(dout), .rd_array(rd_array), .ident(ident), .verify(verify),
    .busy(busy), .erase_go(erase_go), .prog_go(prog_go),
    .prog_addr(prog_addr), .prog_data(prog_data), .timeout(timeout)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [7:0] init_val(int i);
    return 8'(i) ^ 8'hA5;
  endfunction

  // Behavioural cell array
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < (1<<MW); i++) mem[i] <= init_val(i);
    end else if (erase_go) begin
      for (int i = 0; i < (1<<MW); i++) mem[i] <= 8'hFF;
    end else if (prog_go) begin
      mem[prog_addr[MW-1:0]] <= mem[prog_addr[MW-1:0]] & prog_data;
    end
  end

  assign arr_q = mem[arr_addr[MW-1:0]];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = dout;
  endtask

  task automatic t_reset;
    chk("R3 reset rd_array", 32'(rd_array), 1);
    chk("R3 reset busy", 32'(busy), 0);
    chk("R3 reset dout", 32'(dout), 0);
  endtask

  task automatic t_read;
    logic [7:0] d;
    wr(17'h0, 8'h00);
    chk("R3 rd_array", 32'(rd_array), 1);
    rd(17'h5, d);
    chk("R3 read 005", 32'(d), 32'(init_val(5)));
    rd(17'h3FF, d);
    chk("R3 read 3FF", 32'(d), 32'(init_val(32'h3FF)));
  endtask

  task automatic t_ident;
    logic [7:0] d;
    wr(17'h0, 8'h90);
    chk("R4 ident", 32'(ident), 1);
    rd(17'h0, d);
    chk("R4 maker code", 32'(d), 32'h20);
    rd(17'h1, d);
    chk("R4 device code", 32'(d), 32'h07);
    rd(17'h0, d);
    chk("R4 persists", 32'(d), 32'h20);
    wr(17'h0, 8'h00);
    rd(17'h5, d);
    chk("R4 left by 00h", 32'(d), 32'(init_val(5)));
  endtask

  task automatic t_program;
    logic [7:0] d;
    wr(17'h0, 8'h40);
    wr(17'h010, 8'h3C);
    chk("R6 prog_go", 32'(prog_go), 1);
    chk("R6 prog_addr", 32'(prog_addr), 32'h010);
    chk("R6 prog_data", 32'(prog_data), 32'h3C);
    chk("R6 busy", 32'(busy), 1);
    wr(17'h0, 8'hC0);
    chk("R12 busy ends", 32'(busy), 0);
    chk("R8 verify", 32'(verify), 1);
    rd(17'h200, d);
    chk("R8 verify data", 32'(d), 32'(init_val(16'h10) & 8'h3C));
  endtask

  task automatic t_erase;
    logic [7:0] d;
    wr(17'h0, 8'h20);
    wr(17'h0, 8'h33);
    chk("R5 no erase on bad confirm", 32'(erase_go), 0);
    chk("R5 back to read", 32'(rd_array), 1);
    rd(17'h7, d);
    chk("R5 array kept", 32'(d), 32'(init_val(7)));
    wr(17'h0, 8'h20);
    wr(17'h0, 8'h20);
    chk("R5 erase_go", 32'(erase_go), 1);
    chk("R5 busy", 32'(busy), 1);
    @(negedge clk);
    chk("R5 erase_go one cycle", 32'(erase_go), 0);
    wr(17'h022, 8'hA0);
    chk("R7 verify", 32'(verify), 1);
    chk("R12 busy ends", 32'(busy), 0);
    rd(17'h005, d);
    chk("R7 erased byte", 32'(d), 32'hFF);
  endtask

  task automatic t_reset_cmd;
    wr(17'h0, 8'h90);
    wr(17'h0, 8'hFF);
    wr(17'h0, 8'hFF);
    chk("R9 reset pair", 32'(rd_array), 1);
    wr(17'h0, 8'hFF);
    wr(17'h0, 8'h90);
    chk("R9 second byte decoded", 32'(ident), 1);
  endtask

  task automatic t_bad;
    wr(17'h0, 8'h55);
    chk("R11 unknown byte", 32'(rd_array), 1);
    chk("R11 ident off", 32'(ident), 0);
  endtask

  task automatic t_timeout;
    logic [7:0] d;
    int hi;
    wr(17'h0, 8'h40);
    wr(17'h040, 8'h0F);
    hi = 1;
    for (int i = 0; i < STOP + 5; i++) begin
      @(negedge clk);
      if (!busy) break;
      hi++;
    end
    chk("R10 busy cycles", 32'(hi), 32'(STOP));
    chk("R10 timeout pulse", 32'(timeout), 1);
    chk("R10 halted modes", 32'({rd_array, ident, verify}), 0);
    rd(17'h040, d);
    chk("R10 halted read", 32'(d), 0);
    chk("R10 timeout one cycle", 32'(timeout), 0);
    wr(17'h0, 8'hC0);
    rd(17'h0, d);
    chk("R10 verify after halt", 32'(d), 32'h0F);
  endtask

  task automatic t_vpp;
    wr(17'h0, 8'h90);
    @(negedge clk);
    vpp_hi = 1'b0;
    @(negedge clk);
    chk("R1 low supply read", 32'(rd_array), 1);
    wr(17'h0, 8'h90);
    chk("R1 write ignored", 32'(ident), 0);
    vpp_hi = 1'b1;
    wr(17'h0, 8'h40);
    wr(17'h050, 8'hF0);
    chk("R1 busy before drop", 32'(busy), 1);
    vpp_hi = 1'b0;
    @(negedge clk);
    chk("R1 busy cleared", 32'(busy), 0);
    vpp_hi = 1'b1;
  endtask

  task automatic t_lock;
    wr(17'h0, 8'h00);
    lockout = 1'b1;
    wr(17'h0, 8'h90);
    chk("R2 locked write", 32'({rd_array, ident}), 32'b10);
    lockout = 1'b0;
    wr(17'h0, 8'h90);
    chk("R2 unlocked write", 32'(ident), 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    rst_n = 1'b0; vpp_hi = 1'b1; lockout = 1'b0;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    rd_en = 1'b0; rd_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_read();
    t_ident();
    t_program();
    t_erase();
    t_reset_cmd();
    t_bad();
    t_timeout();
    t_vpp();
    t_lock();
    repeat (2) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule